// File: doc/BRIEF.md
# Mode-Gated SPI Master with Word FIFOs

This block is a register-mapped serial peripheral interface master with a four-word transmit queue and a four-word receive queue. A mode field in the master-control register moves it between two states. In configuration mode software programs the clock divider, word length, clock polarity, clock phase, bit order, receive threshold and interrupt enable. In active mode each word written to the data port is shifted out on `mosi`, and the word clocked in on `miso` at the same time is stored in the receive queue.

Software normally loads up to four words, waits for the receive level interrupt, and then drains the receive queue through the data port. Writing zero still produces a full word on the wire, so a receive-only transfer needs no special case. Chip select is not generated here; general-purpose pins drive it.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the mode field reads 01 (control register at offset 0x00 reads 0x0040), both queues are empty, status at 0x14 reads 0x0004 (idle set), and `irq` and `sclk` are low.
- R2: Control register bits [7:6] select the mode: 01 is configuration and 10 is active. Writes to the offset 0x04 and 0x08 setup registers change nothing unless the mode is 01.
- R3: Data port writes at 0x18 are accepted only in active mode. A word is sent MSB first when 0x04 bit 2 is 1 and LSB first when it is 0. Its length is 16 bits when 0x08 bits [4:0] equal 16, and 8 bits otherwise. Reading the data port pops the oldest received word, right-aligned, with the upper byte zero for 8-bit words.
- R4: When no word is in flight, `sclk` rests at 0x04 bit 0. With 0x04 bit 1 = 0, `miso` is sampled on the edge leaving the rest level and `mosi` changes on the returning edge. With bit 1 = 1, these two edges swap roles.
- R5: One `sclk` period lasts 2n clock cycles, where n is 0x08 bits [15:8] and n = 0 acts as 1. Divider and word length are captured at the moment active mode is entered.
- R6: Each queue holds 4 words, and data writes to a full transmit queue are dropped. Status bits [13:11] give the transmit count and bits [10:8] the receive count. A data write in the cycle the shifter takes a word leaves the transmit count unchanged.
- R7: The receive threshold is 0x04 bits [13:12] plus 1. Status bit 14 is set while the receive count is at least the threshold, and `irq` equals that flag ANDed with 0x04 bit 9, as a level.
- R8: Status bit 2 is set exactly when the transmit queue is empty and no word is being shifted.
- R9: Writing the control register with bit 0 set empties both queues. The bit is a strobe and reads back as 0.
- R10: While control bit 1 is set, no new word starts; words already queued stay queued.
- R11: No word starts while the receive queue holds 4 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (base clock is half this rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at 0x18) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Receive threshold interrupt, level |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A software push into the transmit queue and the shifter taking the head word can land in the same cycle. The bench provokes this with two data writes on consecutive clocks into an idle active block. It then reads status at once, expecting a transmit count of one, and afterwards checks that both words come back in order. A receive push by the shifter is also made to fall close to a software pop, and the receive count and interrupt level are judged at the ports.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [4:0] A_MCTL = 5'h00;
  localparam logic [4:0] A_CTL0 = 5'h04;
  localparam logic [4:0] A_CTL1 = 5'h08;
  localparam logic [4:0] A_STAT = 5'h14;
  localparam logic [4:0] A_DATA = 5'h18;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_CFG  = 2'b01,
    MODE_ACT  = 2'b10,
    MODE_RSV  = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic [1:0] thr_m1;
    logic       rx_ie;
    logic       msb_first;
    logic       cpha;
    logic       cpol;
  } ctl0_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_nx, rp_q, rp_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_nx  = wp_q;
    rp_nx  = rp_q;
    cnt_nx = cnt_q;
    if (clr) begin
      wp_nx  = '0;
      rp_nx  = '0;
      cnt_nx = '0;
    end else begin
      if (do_push) wp_nx = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_nx = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_nx = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_nx;
      rp_q  <= rp_nx;
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= wdata;
  end

  // R6
  fifo_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));

  // R9
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] div,
  input  logic          len16,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          msb_first,
  input  logic [W-1:0]  tx_word,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rx_word,
  output logic          sclk,
  output logic          mosi
);
  localparam int EW = $clog2(2*W+1);
  localparam int HW = W/2;

  logic [DW-1:0] cnt_q, cnt_nx, reload;
  logic [EW-1:0] ecnt_q, ecnt_nx;
  logic          busy_q, busy_nx, lead_q, lead_nx, sclk_q, sclk_nx, mosi_q, mosi_nx;
  logic [W-1:0]  txs_q, txs_nx, rxs_q, rxs_nx, txs_sh, rxs_sh, rx_fin, ld_sh;
  logic          tick, samp, drv, last, cur_bit, ld_bit;

  assign reload = (div == '0) ? '0 : div - 1'b1;
  assign tick   = busy_q && (cnt_q == '0);
  assign samp   = tick && (lead_q ^ cpha);
  assign drv    = tick && !(lead_q ^ cpha);
  assign last   = tick && (ecnt_q == EW'(1));

  assign cur_bit = msb_first ? (len16 ? txs_q[W-1] : txs_q[HW-1]) : txs_q[0];
  assign ld_bit  = msb_first ? (len16 ? tx_word[W-1] : tx_word[HW-1]) : tx_word[0];
  assign txs_sh  = msb_first ? (txs_q << 1) : (txs_q >> 1);
  assign ld_sh   = msb_first ? (tx_word << 1) : (tx_word >> 1);
  assign rxs_sh  = msb_first ? {rxs_q[W-2:0], miso} : {miso, rxs_q[W-1:1]};
  assign rx_fin  = samp ? rxs_sh : rxs_q;

  always_comb begin
    if (len16)          rx_word = rx_fin;
    else if (msb_first) rx_word = {{HW{1'b0}}, rx_fin[HW-1:0]};
    else                rx_word = {{HW{1'b0}}, rx_fin[W-1:HW]};
  end

  always_comb begin
    busy_nx = busy_q;
    cnt_nx  = cnt_q;
    ecnt_nx = ecnt_q;
    lead_nx = lead_q;
    sclk_nx = sclk_q;
    mosi_nx = mosi_q;
    txs_nx  = txs_q;
    rxs_nx  = rxs_q;
    if (go && !busy_q) begin
      busy_nx = 1'b1;
      cnt_nx  = reload;
      ecnt_nx = len16 ? EW'(2*W) : EW'(W);
      lead_nx = 1'b1;
      sclk_nx = cpol;
      rxs_nx  = '0;
      txs_nx  = tx_word;
      if (!cpha) begin
        mosi_nx = ld_bit;
        txs_nx  = ld_sh;
      end
    end else if (busy_q) begin
      if (tick) begin
        cnt_nx  = reload;
        ecnt_nx = ecnt_q - 1'b1;
        lead_nx = !lead_q;
        sclk_nx = !sclk_q;
        if (samp) rxs_nx = rxs_sh;
        if (drv) begin
          mosi_nx = cur_bit;
          txs_nx  = txs_sh;
        end
        if (last) busy_nx = 1'b0;
      end else begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ecnt_q <= '0;
      lead_q <= 1'b1;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
    end else begin
      busy_q <= busy_nx;
      cnt_q  <= cnt_nx;
      ecnt_q <= ecnt_nx;
      lead_q <= lead_nx;
      sclk_q <= sclk_nx;
      mosi_q <= mosi_nx;
      txs_q  <= txs_nx;
      rxs_q  <= rxs_nx;
    end
  end

  assign busy = busy_q;
  assign done = last;
  assign sclk = busy_q ? sclk_q : cpol;
  assign mosi = mosi_q;

  // R4
  engine_rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (sclk_q == cpol));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  import spi_fifo_pkg::*;
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  op_mode_e          mode_q, mode_nx;
  logic              stop_q, stop_nx;
  ctl0_t             ctl0_q, ctl0_nx;
  logic [DIV_W-1:0]  div_q, div_nx, div_s_q, div_s_nx;
  logic [4:0]        wlen_q, wlen_nx;
  logic              len16_s_q, len16_s_nx;

  logic wr_mctl, wr_ctl0, wr_ctl1, wr_data, rd_data, cfg, active, enter_act, clr;
  logic go, busy, done, rx_flag;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [2:0]        thr;

  assign wr_mctl   = bus_wr && (bus_addr == A_MCTL);
  assign wr_ctl0   = bus_wr && (bus_addr == A_CTL0);
  assign wr_ctl1   = bus_wr && (bus_addr == A_CTL1);
  assign wr_data   = bus_wr && (bus_addr == A_DATA);
  assign rd_data   = bus_rd && (bus_addr == A_DATA);
  assign cfg       = (mode_q == MODE_CFG);
  assign active    = (mode_q == MODE_ACT);
  assign clr       = wr_mctl && bus_wdata[0];
  assign enter_act = (mode_nx == MODE_ACT) && !active;

  always_comb begin
    mode_nx    = mode_q;
    stop_nx    = stop_q;
    ctl0_nx    = ctl0_q;
    div_nx     = div_q;
    wlen_nx    = wlen_q;
    div_s_nx   = div_s_q;
    len16_s_nx = len16_s_q;
    if (wr_mctl) begin
      mode_nx = op_mode_e'(bus_wdata[7:6]);
      stop_nx = bus_wdata[1];
    end
    if (wr_ctl0 && cfg) begin
      ctl0_nx.thr_m1    = bus_wdata[13:12];
      ctl0_nx.rx_ie     = bus_wdata[9];
      ctl0_nx.msb_first = bus_wdata[2];
      ctl0_nx.cpha      = bus_wdata[1];
      ctl0_nx.cpol      = bus_wdata[0];
    end
    if (wr_ctl1 && cfg) begin
      div_nx  = bus_wdata[15:8];
      wlen_nx = bus_wdata[4:0];
    end
    if (enter_act) begin
      div_s_nx   = div_q;
      len16_s_nx = (wlen_q == 5'd16);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_CFG;
      stop_q    <= 1'b0;
      ctl0_q    <= '0;
      div_q     <= '0;
      wlen_q    <= '0;
      div_s_q   <= '0;
      len16_s_q <= 1'b0;
    end else begin
      mode_q    <= mode_nx;
      stop_q    <= stop_nx;
      ctl0_q    <= ctl0_nx;
      div_q     <= div_nx;
      wlen_q    <= wlen_nx;
      div_s_q   <= div_s_nx;
      len16_s_q <= len16_s_nx;
    end
  end

  assign go = active && !stop_q && !busy && !tx_empty && !rx_full;

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_ni), .clr(clr), .push(wr_data && active), .pop(go),
    .wdata(bus_wdata), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_ni), .clr(clr), .push(done), .pop(rd_data),
    .wdata(rx_word), .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_shift_engine #(.W(DATA_W), .DW(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_ni), .go(go), .div(div_s_q), .len16(len16_s_q),
    .cpol(ctl0_q.cpol), .cpha(ctl0_q.cpha), .msb_first(ctl0_q.msb_first),
    .tx_word(tx_head), .miso(miso), .busy(busy), .done(done), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi));

  assign thr     = {1'b0, ctl0_q.thr_m1} + 3'd1;
  assign rx_flag = (3'(rx_cnt) >= thr);
  assign irq     = rx_flag && ctl0_q.rx_ie;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MCTL: bus_rdata = {8'h00, mode_q, 4'h0, stop_q, 1'b0};
      A_CTL0: bus_rdata = {2'b00, ctl0_q.thr_m1, 2'b00, ctl0_q.rx_ie, 6'h00,
                           ctl0_q.msb_first, ctl0_q.cpha, ctl0_q.cpol};
      A_CTL1: bus_rdata = {div_q, 3'b000, wlen_q};
      A_STAT: bus_rdata = {1'b0, rx_flag, 3'(tx_cnt), 3'(rx_cnt), 5'h00,
                           (tx_empty && !busy), 2'b00};
      A_DATA: bus_rdata = rx_empty ? '0 : rx_head;
      default: bus_rdata = '0;
    endcase
  end

  // R2
  cfg_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_ctl1 && !cfg) |=> ($stable(div_q) && $stable(wlen_q)));

  // R5
  act_latch_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (active && $past(mode_q) != MODE_ACT) |-> (div_s_q == $past(div_q)));

  // R11
  rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_full && !busy) |=> !busy);
endmodule

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb;
  logic        clk, rst_n, bus_wr, bus_rd, miso;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq, sclk, mosi;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic b_cpol = 0, b_cpha = 0, b_inv = 0, armed = 0;
  logic [15:0] cap;
  int capn;
  longint t_last, t_prev;

  spi_fifo_master u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso));

  initial clk = 0;
  always #5 clk = ~clk;
  assign miso = mosi ^ b_inv;

  always @(sclk) if (armed) begin
    if (sclk != b_cpol) begin t_prev = t_last; t_last = $time; end
    if ((sclk != b_cpol) ^ b_cpha) begin cap = {cap[14:0], mosi}; capn++; end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_idle(int rxn);
    logic [15:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(5'h14, s);
      if (s[2] && s[10:8] == rxn[2:0]) return;
    end
  endtask

  function automatic logic [15:0] rev(logic [15:0] v, int n);
    logic [15:0] r = 0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  task automatic setup(logic cp, logic ch, logic msb, logic [1:0] th, logic ie,
                       logic [7:0] dv, logic l16, logic inv);
    wr(5'h00, 16'h0041);
    wr(5'h04, {2'b00, th, 2'b00, ie, 6'h00, msb, ch, cp});
    wr(5'h08, {dv, 3'b000, l16 ? 5'd16 : 5'd8});
    b_cpol = cp; b_cpha = ch; b_inv = inv;
    wr(5'h00, 16'h0080);
    cap = 0; capn = 0; armed = 1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(5'h14, d); chk("R1 status", d, 16'h0004);
    rd(5'h00, d); chk("R1 mode", d, 16'h0040);
    chk("R1 irq", irq, 0);
    chk("R1 sclk", sclk, 0);
  endtask

  task automatic t_cfg_gate();
    logic [15:0] d;
    wr(5'h08, 16'h0308); rd(5'h08, d); chk("R2 ctl1 cfg write", d, 16'h0308);
    wr(5'h00, 16'h0080);
    wr(5'h08, 16'hFF10); rd(5'h08, d); chk("R2 ctl1 ignored in active", d, 16'h0308);
    wr(5'h04, 16'h0207); rd(5'h04, d); chk("R2 ctl0 ignored in active", d, 16'h0000);
    wr(5'h00, 16'h0040);
    wr(5'h18, 16'h00AA); rd(5'h14, d); chk("R3 data ignored in cfg", d, 16'h0004);
  endtask

  task automatic t_xfer(logic cp, logic ch, logic msb, logic l16, logic [7:0] dv,
                        logic inv, logic [15:0] w);
    logic [15:0] d, mask, exp_cap;
    int n = l16 ? 16 : 8;
    longint per = 2 * ((dv == 0) ? 1 : dv) * 10;
    mask = l16 ? 16'hFFFF : 16'h00FF;
    exp_cap = msb ? (w & mask) : rev(w & mask, n);
    setup(cp, ch, msb, 2'b00, 1'b0, dv, l16, inv);
    wr(5'h18, w);
    wait_idle(1);
    rd(5'h18, d);
    chk("R3 rx word", d, (w ^ (inv ? 16'hFFFF : 16'h0)) & mask);
    chk("R3 tx bit order", cap & mask, exp_cap);
    chk("R4 sampled bit count", capn, n);
    chk("R5 sclk period", t_last - t_prev, per);
    chk("R4 rest level", sclk, cp);
  endtask

  task automatic t_thresh();
    logic [15:0] d;
    setup(0, 0, 1, 2'b01, 1'b1, 8'd1, 1'b1, 1'b0);
    wr(5'h18, 16'h1111); wait_idle(1);
    chk("R7 irq below threshold", irq, 0);
    rd(5'h14, d); chk("R7 flag below threshold", d[14], 0);
    wr(5'h18, 16'h2222); wait_idle(2);
    chk("R7 irq at threshold", irq, 1);
    rd(5'h18, d); chk("R3 oldest first", d, 16'h1111);
    chk("R7 irq drops after pop", irq, 0);
    rd(5'h18, d); chk("R3 second word", d, 16'h2222);
    setup(0, 0, 1, 2'b00, 1'b0, 8'd1, 1'b0, 1'b0);
    wr(5'h18, 16'h0000); wait_idle(1);
    rd(5'h14, d); chk("R7 flag without enable", d[14], 1);
    chk("R7 irq masked", irq, 0);
    rd(5'h18, d); chk("R3 zero word read", d, 16'h0000);
  endtask

  task automatic t_fifo_stop();
    logic [15:0] d;
    setup(0, 0, 1, 2'b11, 1'b1, 8'd1, 1'b0, 1'b0);
    wr(5'h00, 16'h0082);
    for (int i = 1; i <= 5; i++) wr(5'h18, 16'(i * 16'h11));
    rd(5'h14, d); chk("R6 tx count full, R8 not idle", d, 16'h2000);
    repeat (50) @(negedge clk);
    rd(5'h14, d); chk("R10 stop holds queue", d, 16'h2000);
    wr(5'h00, 16'h0080);
    wait_idle(4);
    chk("R7 irq at threshold 4", irq, 1);
    rd(5'h14, d); chk("R8 idle with rx full", d, 16'h4404);
    wr(5'h18, 16'h0066);
    repeat (200) @(negedge clk);
    rd(5'h14, d); chk("R11 no start while rx full", d, 16'h4C00);
    for (int i = 1; i <= 4; i++) begin
      rd(5'h18, d); chk("R6 fifo order, fifth dropped", d, 16'(i * 16'h11));
    end
    wait_idle(1);
    rd(5'h18, d); chk("R11 held word sent later", d, 16'h0066);
    wr(5'h00, 16'h0082);
    wr(5'h18, 16'h0077); wr(5'h18, 16'h0088);
    wr(5'h00, 16'h0083);
    rd(5'h14, d); chk("R9 clear empties queues", d, 16'h0004);
    rd(5'h00, d); chk("R9 strobe not stored", d, 16'h0082);
  endtask

  task automatic t_b2b();
    logic [15:0] d;
    setup(0, 0, 1, 2'b00, 1'b0, 8'd3, 1'b0, 1'b0);
    wr(5'h18, 16'h00A1);
    wr(5'h18, 16'h00B2);
    rd(5'h14, d); chk("R6 push and pop same cycle", d, 16'h0800);
    wait_idle(2);
    rd(5'h18, d); chk("R6 b2b first", d, 16'h00A1);
    rd(5'h18, d); chk("R6 b2b second", d, 16'h00B2);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cfg_gate();
    t_xfer(0, 0, 1, 0, 8'd3, 0, 16'h00A5);
    t_xfer(1, 1, 0, 1, 8'd2, 1, 16'h1234);
    t_xfer(0, 1, 1, 1, 8'd0, 0, 16'hC35A);
    t_xfer(1, 0, 0, 0, 8'd1, 1, 16'h003C);
    t_xfer(0, 0, 1, 0, 8'd2, 1, 16'h0000);
    t_thresh();
    t_fifo_stop();
    t_b2b();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule